// File: doc/BRIEF.md
# Request Command Front End for a Lookup Engine

This block is the host-facing side of a content lookup engine. A host reaches it over a synchronous bus: chip select, write enable, a 4-bit address and a 17-bit data word. The top data bit is a parity line. It makes each transfer, address included, carry odd parity. The block checks that parity on every write and generates it on every read.

The host builds a request from a short series of register writes and then polls a status word. The address chooses both the register that is loaded and the action that follows. Some registers can therefore be loaded through more than one address: one address loads without side effects, and another loads and also starts the engine. A request starts a search, a line write or a line read in the engine. Then the block reports busy until the engine signals done. After that it reports success, alarm or error as a two-bit code, and it keeps the engine's result for readback.

A separate test request goes through a staging register. One field of the write selects the mode register, the test-config register or one of four fixed version octets. Another bit chooses modify-and-read or read only. A self-clearing bit in the same write damages the parity of the next read, so the host can test its own parity checker.

Top module: `req_front`

## Requirements
- R1: On a write, parity is good when the ones in {addr, wdata[16:0]} are odd in number. A write with bad parity changes no register, starts nothing and sets status code 11.
- R2: On every read, rdata[16] is chosen so that the ones in {addr of the read, rdata[16:0]} are odd in number. R9 is the only exception.
- R3: Write address map. 0 loads key bits 15:0. 1 loads key bits 31:16 and starts a search (eng_op 00). 2 loads key bits 31:16 only. 3 loads the index from wdata[13:0] and starts a line write (eng_op 01). 4 loads the index and starts a line read (eng_op 10). 5 is the test request. Writes to addresses 6 to 15 are ignored. Read address map: 6 returns status, 7 returns the result, 9 returns the test data, and every other address returns 0.
- R4: eng_start is a one-cycle pulse in the cycle after an accepted starting write. The block is busy from that cycle until eng_done.
- R5: Status bits 1:0 hold the code: 00 success, 01 busy, 10 alarm (eng_alarm with eng_done), 11 error. Busy takes priority over error, and error over alarm. Error and alarm clear when the next request is accepted at address 1, 3, 4 or 5.
- R6: While busy, every write is ignored and sets the error flag. Status and result reads are still served.
- R7: On eng_done, eng_result is captured and then read at address 7.
- R8: For a test write, wdata[2:0] selects the target: 0 is the mode register (cfg_mode), 1 is the test-config register (cfg_test), and 4 to 7 are version octets 0 to 3. If wdata[3] is set, wdata[11:4] is written to the mode or test-config register. The test data then returns the selected register's value, taken after that write.
- R9: If wdata[12] is set on a test write, the next read returns inverted parity. The bit then clears itself.
- R10: Version octet k is VERSION[8k+7:8k], with a default of A5, 3C, 01, 02 for k = 0 to 3. A modify write does not change it.
- R11: After reset, every register reads 0000h, the key, index, cfg_mode and cfg_test are 0, and the status code is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Bus chip select |
| we | input | 1 | Bus write enable (0 means a read) |
| addr | input | 4 | Register address |
| wdata | input | 17 | Write data; bit 16 is parity |
| rdata | output | 17 | Read data, valid one cycle after the read; bit 16 is parity |
| eng_start | output | 1 | One-cycle request start to the engine |
| eng_op | output | 2 | Operation: 00 search, 01 line write, 10 line read |
| eng_key | output | 32 | Key or line contents |
| eng_index | output | 14 | Line index |
| eng_done | input | 1 | Engine finished the current request |
| eng_alarm | input | 1 | Outcome qualifier sampled with eng_done |
| eng_result | input | 16 | Engine result sampled with eng_done |
| cfg_mode | output | 8 | Mode register |
| cfg_test | output | 8 | Test-config register |

## Verification
A sequencer stuck in busy shows up as status code 01 on the first poll after eng_done. A busy flag that clears too early shows up as a second eng_start, or as a changed eng_key, one cycle after a write made during the request. A parity register that is wrong in either direction shows in bit 16 of the very next read. If the self-clearing test bit fails to clear, the read after the damaged one also has bad parity. Errors in the error and alarm flags show in the next status read as the wrong code.

// File: rtl/req_pkg.sv
package req_pkg;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_KEY_LO  = 4'h0;
    localparam logic [ADDR_W-1:0] A_KEY_GO  = 4'h1;
    localparam logic [ADDR_W-1:0] A_KEY_HI  = 4'h2;
    localparam logic [ADDR_W-1:0] A_IDX_WR  = 4'h3;
    localparam logic [ADDR_W-1:0] A_IDX_RD  = 4'h4;
    localparam logic [ADDR_W-1:0] A_TEST    = 4'h5;
    localparam logic [ADDR_W-1:0] A_STATUS  = 4'h6;
    localparam logic [ADDR_W-1:0] A_RESULT  = 4'h7;
    localparam logic [ADDR_W-1:0] A_TDATA   = 4'h9;

    typedef enum logic [1:0] {
        OP_SEARCH = 2'b00,
        OP_WRLINE = 2'b01,
        OP_RDLINE = 2'b10
    } eng_op_e;

    typedef enum logic [1:0] {
        ST_OK    = 2'b00,
        ST_BUSY  = 2'b01,
        ST_ALARM = 2'b10,
        ST_ERR   = 2'b11
    } stat_e;
endpackage

// File: rtl/req_parity.sv
module req_parity #(
    parameter int W = 21
) (
    input  logic [W-1:0] vec,
    output logic         odd
);
    always_comb odd = ^vec;
endmodule

// File: rtl/req_seq.sv
module req_seq
    import req_pkg::*;
#(
    parameter int DW = 16,
    parameter int IW = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                par_ok,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DW-1:0]       data,
    input  logic                eng_done,
    input  logic                eng_alarm,
    input  logic [DW-1:0]       eng_result,
    output logic                busy,
    output logic                start,
    output eng_op_e             op,
    output logic [2*DW-1:0]     key,
    output logic [IW-1:0]       index,
    output logic [DW-1:0]       result,
    output stat_e               code
);
    typedef struct packed {
        logic [DW-1:0] key_lo;
        logic [DW-1:0] key_hi;
        logic [IW-1:0] idx;
        logic          busy;
        logic          err;
        logic          alarm;
        logic          start;
        eng_op_e       op;
        logic [DW-1:0] res;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d = q;
        d.start = 1'b0;
        if (bus_wr) begin
            if (!par_ok || q.busy) begin
                d.err = 1'b1;
            end else begin
                case (addr)
                    A_KEY_LO: d.key_lo = data;
                    A_KEY_HI: d.key_hi = data;
                    A_KEY_GO: begin
                        d.key_hi = data;
                        d.op     = OP_SEARCH;
                        d.start  = 1'b1;
                        d.busy   = 1'b1;
                        d.err    = 1'b0;
                        d.alarm  = 1'b0;
                    end
                    A_IDX_WR: begin
                        d.idx   = data[IW-1:0];
                        d.op    = OP_WRLINE;
                        d.start = 1'b1;
                        d.busy  = 1'b1;
                        d.err   = 1'b0;
                        d.alarm = 1'b0;
                    end
                    A_IDX_RD: begin
                        d.idx   = data[IW-1:0];
                        d.op    = OP_RDLINE;
                        d.start = 1'b1;
                        d.busy  = 1'b1;
                        d.err   = 1'b0;
                        d.alarm = 1'b0;
                    end
                    A_TEST: begin
                        d.err   = 1'b0;
                        d.alarm = 1'b0;
                    end
                    default: ;
                endcase
            end
        end
        if (q.busy && eng_done) begin
            d.busy  = 1'b0;
            d.res   = eng_result;
            d.alarm = eng_alarm;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        busy   = q.busy;
        start  = q.start;
        op     = q.op;
        key    = {q.key_hi, q.key_lo};
        index  = q.idx;
        result = q.res;
        if (q.busy)       code = ST_BUSY;
        else if (q.err)   code = ST_ERR;
        else if (q.alarm) code = ST_ALARM;
        else              code = ST_OK;
    end
endmodule

// File: rtl/req_testreg.sv
module req_testreg #(
    parameter int          CW      = 8,
    parameter int          NVER    = 4,
    parameter logic [31:0] VERSION = 32'h0201_3CA5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tst_wr,
    input  logic [12:0]   data,
    input  logic          rd_strobe,
    output logic [CW-1:0] mode,
    output logic [CW-1:0] tcfg,
    output logic [CW-1:0] tdat,
    output logic          bad_par
);
    typedef struct packed {
        logic [CW-1:0] mode;
        logic [CW-1:0] tcfg;
        logic [CW-1:0] tdat;
        logic          badp;
    } tst_t;

    tst_t q, d;
    logic [CW-1:0] ver [NVER];

    for (genvar k = 0; k < NVER; k++) begin : g_ver
        assign ver[k] = VERSION[k*CW +: CW];
    end

    logic [2:0]    sel;
    logic          modify;
    logic [CW-1:0] val;

    always_comb begin
        sel    = data[2:0];
        modify = data[3];
        val    = data[4 +: CW];
        d = q;
        if (rd_strobe && q.badp) d.badp = 1'b0;
        if (tst_wr) begin
            d.badp = data[12];
            case (sel)
                3'd0: begin
                    if (modify) d.mode = val;
                    d.tdat = modify ? val : q.mode;
                end
                3'd1: begin
                    if (modify) d.tcfg = val;
                    d.tdat = modify ? val : q.tcfg;
                end
                3'd4, 3'd5, 3'd6, 3'd7: d.tdat = ver[sel[1:0]];
                default: d.tdat = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mode    = q.mode;
    assign tcfg    = q.tcfg;
    assign tdat    = q.tdat;
    assign bad_par = q.badp;
endmodule

// File: rtl/req_front.sv
module req_front
    import req_pkg::*;
#(
    parameter int          DW      = 16,
    parameter int          IW      = 14,
    parameter int          CW      = 8,
    parameter logic [31:0] VERSION = 32'h0201_3CA5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DW:0]          wdata,
    output logic [DW:0]          rdata,
    output logic                 eng_start,
    output logic [1:0]           eng_op,
    output logic [2*DW-1:0]      eng_key,
    output logic [IW-1:0]        eng_index,
    input  logic                 eng_done,
    input  logic                 eng_alarm,
    input  logic [DW-1:0]        eng_result,
    output logic [CW-1:0]        cfg_mode,
    output logic [CW-1:0]        cfg_test
);
    localparam int PW = ADDR_W + DW + 1;

    typedef struct packed {
        logic              vld;
        logic              bad;
        logic [ADDR_W-1:0] addr;
        logic [DW-1:0]     data;
    } rd_t;

    rd_t rd_q, rd_d;

    logic          wr_odd, par_ok, bus_wr, bus_rd, busy, tst_wr, bad_par;
    logic          gen_odd;
    eng_op_e       op;
    stat_e         code;
    logic [DW-1:0] result;
    logic [CW-1:0] tdat;

    assign bus_wr = cs && we;
    assign bus_rd = cs && !we;

    req_parity #(.W(PW)) u_chk_par (.vec({addr, wdata}), .odd(wr_odd));
    assign par_ok = wr_odd;

    req_seq #(.DW(DW), .IW(IW)) u_seq (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .par_ok(par_ok),
        .addr(addr), .data(wdata[DW-1:0]),
        .eng_done(eng_done), .eng_alarm(eng_alarm), .eng_result(eng_result),
        .busy(busy), .start(eng_start), .op(op), .key(eng_key),
        .index(eng_index), .result(result), .code(code)
    );

    assign tst_wr = bus_wr && par_ok && !busy && (addr == A_TEST);

    req_testreg #(.CW(CW), .VERSION(VERSION)) u_tst (
        .clk(clk), .rst_n(rst_n), .tst_wr(tst_wr), .data(wdata[12:0]),
        .rd_strobe(bus_rd), .mode(cfg_mode), .tcfg(cfg_test),
        .tdat(tdat), .bad_par(bad_par)
    );

    assign eng_op = op;

    always_comb begin
        rd_d      = rd_q;
        rd_d.vld  = bus_rd;
        if (bus_rd) begin
            rd_d.addr = addr;
            rd_d.bad  = bad_par;
            case (addr)
                A_STATUS: rd_d.data = DW'(code);
                A_RESULT: rd_d.data = result;
                A_TDATA:  rd_d.data = DW'(tdat);
                default:  rd_d.data = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    req_parity #(.W(ADDR_W + DW)) u_gen_par (.vec({rd_q.addr, rd_q.data}), .odd(gen_odd));

    assign rdata = {~gen_odd ^ rd_q.bad, rd_q.data};
endmodule

// File: rtl/req_front_chk.sv
module req_front_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs,
    input logic          we,
    input logic [3:0]    addr,
    input logic [DW:0]   wdata,
    input logic [DW:0]   rdata,
    input logic          eng_start,
    input logic [2*DW-1:0] eng_key,
    input logic          busy,
    input logic          rd_vld,
    input logic          rd_bad,
    input logic [3:0]    rd_addr
);
    // R4
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R4
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> busy);

    // R1
    bad_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && we && !(^{addr, wdata})) |=> !eng_start);

    // R2
    rd_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vld && !rd_bad) |-> (^{rd_addr, rdata}));

    // R6
    busy_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(eng_key));
endmodule

bind req_front req_front_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .eng_start(eng_start), .eng_key(eng_key), .busy(busy),
    .rd_vld(rd_q.vld), .rd_bad(rd_q.bad), .rd_addr(rd_q.addr)
);

// File: tb/sim_req_front.sv
module sim_req_front;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] VER = 32'h0201_3CA5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0, we = 1'b0;
    logic [3:0]  addr = '0;
    logic [16:0] wdata = '0;
    logic [16:0] rdata;
    logic        eng_start;
    logic [1:0]  eng_op;
    logic [31:0] eng_key;
    logic [13:0] eng_index;
    logic        eng_done = 1'b0, eng_alarm = 1'b0;
    logic [15:0] eng_result = '0;
    logic [7:0]  cfg_mode, cfg_test;

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    req_front u0 (.*);

    function automatic logic [16:0] gp(input logic [3:0] a, input logic [15:0] v);
        return {~^{a, v}, v};
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] v, input bit flip = 0);
        @(negedge clk);
        cs = 1; we = 1; addr = a;
        wdata = gp(a, v) ^ (flip ? 17'h10000 : 17'h0);
        @(negedge clk);
        cs = 0; we = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [16:0] v);
        @(negedge clk);
        cs = 1; we = 0; addr = a;
        @(negedge clk);
        cs = 0;
        v = rdata;
    endtask

    task automatic done(input bit al, input logic [15:0] r);
        @(negedge clk);
        eng_done = 1; eng_alarm = al; eng_result = r;
        @(negedge clk);
        eng_done = 0; eng_alarm = 0;
    endtask

    task automatic t_reset;
        logic [16:0] v;
        rd(4'h6, v); check("R11 status after reset", 32'(v), 32'(gp(4'h6, 16'h0)));
        rd(4'h7, v); check("R11 result after reset", 32'(v), 32'(gp(4'h7, 16'h0)));
        check("R11 key after reset", eng_key, 32'h0);
        check("R11 mode after reset", 32'(cfg_mode), 32'h0);
    endtask

    task automatic t_search;
        logic [16:0] v;
        wr(4'h0, 16'h1111);
        check("R3 key low no start", 32'(eng_start), 32'h0);
        wr(4'h1, 16'h2222);
        check("R4 start pulse", 32'(eng_start), 32'h1);
        check("R3 search op", 32'(eng_op), 32'h0);
        check("R3 search key", eng_key, 32'h2222_1111);
        @(negedge clk);
        check("R4 start one cycle", 32'(eng_start), 32'h0);
        rd(4'h6, v); check("R5 busy code", 32'(v), 32'(gp(4'h6, 16'h1)));
        done(0, 16'h0ABC);
        rd(4'h6, v); check("R5 ok code", 32'(v), 32'(gp(4'h6, 16'h0)));
        rd(4'h7, v); check("R7 result", 32'(v), 32'(gp(4'h7, 16'h0ABC)));
    endtask

    task automatic t_alarm;
        logic [16:0] v;
        wr(4'h1, 16'h3333);
        done(1, 16'h0055);
        rd(4'h6, v); check("R5 alarm code", 32'(v), 32'(gp(4'h6, 16'h2)));
        rd(4'h7, v); check("R7 result on alarm", 32'(v), 32'(gp(4'h7, 16'h0055)));
    endtask

    task automatic t_lines;
        logic [16:0] v;
        wr(4'h2, 16'h4444);
        check("R3 key high no start", 32'(eng_start), 32'h0);
        check("R3 key high loaded", eng_key, 32'h4444_1111);
        wr(4'h3, 16'h0123);
        check("R3 line write start", 32'(eng_start), 32'h1);
        check("R3 line write op", 32'(eng_op), 32'h1);
        check("R3 line write index", 32'(eng_index), 32'h123);
        rd(4'h6, v); check("R5 alarm cleared by new request", 32'(v), 32'(gp(4'h6, 16'h1)));
        done(0, 16'h0);
        wr(4'h4, 16'h0456);
        check("R3 line read op", 32'(eng_op), 32'h2);
        check("R3 line read index", 32'(eng_index), 32'h456);
        done(0, 16'h0);
    endtask

    task automatic t_parity;
        logic [16:0] v;
        wr(4'h0, 16'h9999, 1);
        check("R1 bad write discarded", eng_key, 32'h4444_1111);
        rd(4'h6, v); check("R1 bad write error code", 32'(v), 32'(gp(4'h6, 16'h3)));
        wr(4'h1, 16'h5555, 1);
        check("R1 bad start ignored", 32'(eng_start), 32'h0);
    endtask

    task automatic t_busy;
        logic [16:0] v;
        wr(4'h1, 16'h7777);
        check("R5 error cleared by start", 32'(eng_start), 32'h1);
        wr(4'h0, 16'hAAAA);
        check("R6 write while busy ignored", eng_key, 32'h7777_1111);
        wr(4'h1, 16'hBBBB);
        check("R6 no restart while busy", 32'(eng_start), 32'h0);
        rd(4'h6, v); check("R6 status readable while busy", 32'(v), 32'(gp(4'h6, 16'h1)));
        done(0, 16'h0001);
        rd(4'h6, v); check("R6 error after busy write", 32'(v), 32'(gp(4'h6, 16'h3)));
    endtask

    task automatic t_test;
        logic [16:0] v;
        wr(4'h5, 16'h05A8);
        check("R8 mode modified", 32'(cfg_mode), 32'h5A);
        rd(4'h9, v); check("R8 modify and read", 32'(v), 32'(gp(4'h9, 16'h005A)));
        rd(4'h6, v); check("R5 test request clears error", 32'(v), 32'(gp(4'h6, 16'h0)));
        wr(4'h5, 16'h0FF1);
        rd(4'h9, v); check("R8 read-only test-config", 32'(v), 32'(gp(4'h9, 16'h0)));
        check("R8 test-config untouched", 32'(cfg_test), 32'h0);
        wr(4'h5, 16'h0C39);
        check("R8 test-config modified", 32'(cfg_test), 32'hC3);
        wr(4'h5, 16'h0000);
        rd(4'h9, v); check("R8 read-only mode", 32'(v), 32'(gp(4'h9, 16'h005A)));
    endtask

    task automatic t_version;
        logic [16:0] v;
        for (int k = 0; k < 4; k++) begin
            wr(4'h5, 16'(4 + k));
            rd(4'h9, v);
            check("R10 version octet", 32'(v), 32'(gp(4'h9, 16'(VER[k*8 +: 8]))));
        end
        wr(4'h5, 16'h0FFC);
        rd(4'h9, v); check("R10 version not modifiable", 32'(v), 32'(gp(4'h9, 16'h00A5)));
    endtask

    task automatic t_badpar;
        logic [16:0] v;
        wr(4'h5, 16'h1000);
        rd(4'h9, v); check("R9 forced bad parity", 32'(v), 32'(gp(4'h9, 16'h005A) ^ 17'h10000));
        rd(4'h9, v); check("R9 bit clears itself", 32'(v), 32'(gp(4'h9, 16'h005A)));
    endtask

    task automatic t_misc;
        logic [16:0] v;
        wr(4'h6, 16'h0003);
        rd(4'h6, v); check("R3 write to status ignored", 32'(v), 32'(gp(4'h6, 16'h0)));
        rd(4'hF, v); check("R2 unmapped read parity", 32'(v), 32'(gp(4'hF, 16'h0)));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_search();
        t_alarm();
        t_lines();
        t_parity();
        t_busy();
        t_test();
        t_version();
        t_badpar();
        t_misc();
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule